// File: doc/BRIEF.md
# Smart Card Activation and Reset Sequencer

This block powers a contact smart card up and down and runs its cold and warm resets. A control register supplies a start bit and a warm-reset request. The block steps the card supply, I/O enable, card clock and reset line through a fixed order, paced by a card-clock tick. When the host clears the start bit, the block runs the same steps in reverse.

While the reset line is released, the block watches the card I/O line for the first falling edge, which marks the card's answer. It measures that answer in card clock ticks. An answer that starts inside a configurable window is reported as early. If the card stays silent until the mute limit, a mute event is raised instead.

The block also watches for card removal, supply dropout and overload. If any of these occurs while the card is powered, it deactivates the card by itself and asks the register to clear the start bit.

Top module: `sc_card_sequencer`

## Requirements
- R1: After reset, vcc_en, io_en, card_clk_en, card_rst_n, active, start_clr, early_evt and mute_evt are all 0.
- R2: A 0-to-1 change of start_cmd, with the card present and no fault, turns on vcc_en in the next cycle. The following ticks then proceed as follows:
  - tick 1 turns on io_en;
  - tick 2 turns on card_clk_en, with card_rst_n still 0;
  - card_rst_n rises on tick 2+RST_CYCLES.
- R3: After card_rst_n rises, ticks are counted from 1. On the first tick whose sample of card_io_in is 0 while the previous tick's sample was 1, the answer is taken and answer timing stops. card_rst_n stays 1.
- R4: early_evt is a one-cycle pulse issued after the answering tick when the tick index lies between EARLY_LO and EARLY_HI inclusive (200 and 352 by default). Answers outside that range give no pulse.
- R5: If no answer has come by tick index MUTE_LIMIT, a one-cycle mute_evt pulse follows that tick. The card stays powered with card_rst_n at 1.
- R6: With WARM_ANY=0, warm_req has no effect unless a mute occurred since activation. After a mute, warm_req drives card_rst_n to 0 in the next cycle and holds it there for RST_CYCLES ticks. It then releases card_rst_n and restarts answer timing.
- R7: With WARM_ANY=1, warm_req starts a warm reset after an answer as well as during answer timing.
- R8: When start_cmd is 0 while the card is powered, card_rst_n goes to 0 in the next cycle. The next three ticks then remove, in order, card_clk_en, io_en and vcc_en.
- R9: Card absence, supply_fault or overload while the card is powered starts the R8 sequence. It also produces a one-cycle start_clr pulse in the same cycle that card_rst_n drops.
- R10: Activation never starts if the card is absent or a fault is present at the rise of start_cmd. A start_cmd left at 1 after a fault does not restart the card; a fresh 0-to-1 change is needed.
- R11: active is 1 exactly while vcc_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_cmd | input | 1 | Start bit from the control register (1 = run session) |
| warm_req | input | 1 | Warm reset request, sampled each cycle |
| card_present | input | 1 | 1 while a card is inserted |
| supply_fault | input | 1 | Supply supervisor fault |
| overload | input | 1 | Card supply overload |
| card_io_in | input | 1 | Card I/O line level |
| clk_tick | input | 1 | One-cycle strobe per card clock period |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O buffer enable |
| card_clk_en | output | 1 | Card clock enable |
| card_rst_n | output | 1 | Card reset line (0 = in reset) |
| active | output | 1 | Card powered flag |
| start_clr | output | 1 | One-cycle request to clear the start bit |
| early_evt | output | 1 | One-cycle early-answer event |
| mute_evt | output | 1 | One-cycle mute event |

## Verification
The bench places answers at the exact edges of the early window (199, 200, 352 and 353 ticks). A design off by one in its tick index would flag or miss early answers at those points. It also lets the card stay silent up to the mute limit, to show that mute fires on that tick and not one earlier or later. It sends a warm request after a normal answer to two instances that differ only in warm mode: a wrong gate would either reset a card that answered or refuse a legal warm reset. The fault scenarios hold start_cmd at 1 after the automatic shutdown. A design that triggered on the level instead of the edge would power the card straight back up.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PWR,
    ST_IOEN,
    ST_RHOLD,
    ST_AWAIT,
    ST_SESS,
    ST_WHOLD,
    ST_DRST,
    ST_DCLK,
    ST_DIO
  } seq_state_e;

  // One-based tick index from a zero-based count
  function automatic logic [31:0] tick_index(input logic [31:0] cnt);
    return cnt + 32'd1;
  endfunction

  function automatic logic in_early_win(input logic [31:0] idx,
                                        input logic [31:0] lo,
                                        input logic [31:0] hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

  function automatic logic limit_hit(input logic [31:0] idx,
                                     input logic [31:0] lim);
    return idx >= lim;
  endfunction

  // States in which the card may be shut down by command or fault
  function automatic logic is_live(input seq_state_e s);
    return (s == ST_PWR) || (s == ST_IOEN) || (s == ST_RHOLD) ||
           (s == ST_AWAIT) || (s == ST_SESS) || (s == ST_WHOLD);
  endfunction

  function automatic logic supplies_card(input seq_state_e s);
    return s != ST_OFF;
  endfunction

  function automatic logic io_driven(input seq_state_e s);
    return (s != ST_OFF) && (s != ST_PWR) && (s != ST_DIO);
  endfunction

  function automatic logic clock_runs(input seq_state_e s);
    return (s == ST_RHOLD) || (s == ST_AWAIT) || (s == ST_SESS) ||
           (s == ST_WHOLD) || (s == ST_DRST);
  endfunction

  function automatic logic reset_released(input seq_state_e s);
    return (s == ST_AWAIT) || (s == ST_SESS);
  endfunction

endpackage

// File: rtl/sc_hold_timer.sv
module sc_hold_timer
  import sc_seq_pkg::*;
#(
  parameter int unsigned HOLD = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
  end

  assign done = run & tick & limit_hit(tick_index(32'(cnt)), 32'(HOLD));
endmodule

// File: rtl/sc_answer_timer.sv
module sc_answer_timer
  import sc_seq_pkg::*;
#(
  parameter int unsigned MUTE_LIMIT = 90000,
  parameter int unsigned EARLY_LO   = 200,
  parameter int unsigned EARLY_HI   = 352
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic io_in,
  input  logic window_open,
  output logic answer_hit,
  output logic early_hit,
  output logic mute_hit
);
  localparam int unsigned CW = $clog2(MUTE_LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          io_q;
  logic          io_fall;
  logic [31:0]   idx;

  // Line sampled once per card clock tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    io_q <= 1'b1;
    else if (tick) io_q <= io_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!window_open)      cnt <= '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
  end

  assign idx        = tick_index(32'(cnt));
  assign io_fall    = tick & io_q & ~io_in;
  assign answer_hit = window_open & io_fall;
  assign early_hit  = answer_hit & in_early_win(idx, 32'(EARLY_LO), 32'(EARLY_HI));
  assign mute_hit   = window_open & tick & ~io_fall & limit_hit(idx, 32'(MUTE_LIMIT));
endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_seq_pkg::*;
#(
  parameter bit WARM_ANY = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_cmd,
  input  logic       warm_req,
  input  logic       card_present,
  input  logic       supply_fault,
  input  logic       overload,
  input  logic       hold_done,
  input  logic       answer_hit,
  input  logic       early_hit,
  input  logic       mute_hit,
  output seq_state_e state_q,
  output logic       start_clr,
  output logic       early_evt,
  output logic       mute_evt,
  output logic       warm_go,
  output logic       mute_seen
);
  seq_state_e state_d;
  logic start_q, start_rise, fault_now, live, kill, warm_state;

  assign start_rise = start_cmd & ~start_q;
  assign fault_now  = ~card_present | supply_fault | overload;
  assign live       = is_live(state_q);
  assign kill       = live & (fault_now | ~start_cmd);

  generate
    if (WARM_ANY) begin : g_warm_any
      assign warm_state = (state_q == ST_AWAIT) || (state_q == ST_SESS);
    end else begin : g_warm_mute
      assign warm_state = (state_q == ST_SESS) && mute_seen;
    end
  endgenerate

  assign warm_go = ~kill & warm_req & warm_state;

  always_comb begin
    state_d = state_q;
    if (kill) begin
      state_d = ST_DRST;
    end else if (warm_go) begin
      state_d = ST_WHOLD;
    end else begin
      unique case (state_q)
        ST_OFF:   if (start_rise && !fault_now) state_d = ST_PWR;
        ST_PWR:   if (tick) state_d = ST_IOEN;
        ST_IOEN:  if (tick) state_d = ST_RHOLD;
        ST_RHOLD: if (hold_done) state_d = ST_AWAIT;
        ST_AWAIT: if (answer_hit || mute_hit) state_d = ST_SESS;
        ST_SESS:  state_d = ST_SESS;
        ST_WHOLD: if (hold_done) state_d = ST_AWAIT;
        ST_DRST:  if (tick) state_d = ST_DCLK;
        ST_DCLK:  if (tick) state_d = ST_DIO;
        ST_DIO:   if (tick) state_d = ST_OFF;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      start_q   <= 1'b0;
      start_clr <= 1'b0;
      early_evt <= 1'b0;
      mute_evt  <= 1'b0;
      mute_seen <= 1'b0;
    end else begin
      state_q   <= state_d;
      start_q   <= start_cmd;
      start_clr <= live & fault_now;
      early_evt <= early_hit & ~kill & ~warm_go;
      mute_evt  <= mute_hit & ~kill & ~warm_go;
      if (state_q == ST_OFF)                 mute_seen <= 1'b0;
      else if (mute_hit && !kill && !warm_go) mute_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_card_sequencer.sv
module sc_card_sequencer
  import sc_seq_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 400,
  parameter int unsigned MUTE_LIMIT = 90000,
  parameter int unsigned EARLY_LO   = 200,
  parameter int unsigned EARLY_HI   = 352,
  parameter bit          WARM_ANY   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_cmd,
  input  logic warm_req,
  input  logic card_present,
  input  logic supply_fault,
  input  logic overload,
  input  logic card_io_in,
  input  logic clk_tick,
  output logic vcc_en,
  output logic io_en,
  output logic card_clk_en,
  output logic card_rst_n,
  output logic active,
  output logic start_clr,
  output logic early_evt,
  output logic mute_evt
);
  seq_state_e state_q;
  logic hold_run, hold_done, window_open;
  logic answer_hit, early_hit, mute_hit;
  logic warm_go, mute_seen;

  assign hold_run    = (state_q == ST_RHOLD) || (state_q == ST_WHOLD);
  assign window_open = (state_q == ST_AWAIT);

  sc_hold_timer #(.HOLD(RST_CYCLES)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (hold_run),
    .tick (clk_tick),
    .done (hold_done)
  );

  sc_answer_timer #(
    .MUTE_LIMIT(MUTE_LIMIT),
    .EARLY_LO  (EARLY_LO),
    .EARLY_HI  (EARLY_HI)
  ) u_answer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (clk_tick),
    .io_in      (card_io_in),
    .window_open(window_open),
    .answer_hit (answer_hit),
    .early_hit  (early_hit),
    .mute_hit   (mute_hit)
  );

  sc_seq_fsm #(.WARM_ANY(WARM_ANY)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (clk_tick),
    .start_cmd   (start_cmd),
    .warm_req    (warm_req),
    .card_present(card_present),
    .supply_fault(supply_fault),
    .overload    (overload),
    .hold_done   (hold_done),
    .answer_hit  (answer_hit),
    .early_hit   (early_hit),
    .mute_hit    (mute_hit),
    .state_q     (state_q),
    .start_clr   (start_clr),
    .early_evt   (early_evt),
    .mute_evt    (mute_evt),
    .warm_go     (warm_go),
    .mute_seen   (mute_seen)
  );

  assign vcc_en      = supplies_card(state_q);
  assign io_en       = io_driven(state_q);
  assign card_clk_en = clock_runs(state_q);
  assign card_rst_n  = reset_released(state_q);
  assign active      = vcc_en;
endmodule

// File: rtl/sc_card_sequencer_chk.sv
module sc_card_sequencer_chk #(
  parameter bit WARM_ANY = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic vcc_en,
  input logic io_en,
  input logic card_clk_en,
  input logic card_rst_n,
  input logic active,
  input logic start_clr,
  input logic early_evt,
  input logic mute_evt,
  input logic warm_go
);
  logic mute_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mute_flag <= 1'b0;
    else if (!vcc_en)  mute_flag <= 1'b0;
    else if (mute_evt) mute_flag <= 1'b1;
  end

  p_rel_needs_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst_n |-> (card_clk_en && io_en && vcc_en));

  p_rel_after_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst_n) |-> $past(card_clk_en));

  p_power_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (!io_en && !card_clk_en && !card_rst_n));

  p_clk_stop_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk_en) |-> (!card_rst_n && $past(!card_rst_n)));

  p_supply_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> (!io_en && !card_clk_en));

  p_clr_deact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |-> (!card_rst_n && vcc_en));

  p_evt_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({early_evt, mute_evt}));

  p_early_session_r4: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |-> card_rst_n);

  p_mute_powered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mute_evt |-> (card_rst_n && vcc_en));

  p_warm_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warm_go |-> (WARM_ANY || mute_flag || mute_evt));
endmodule

bind sc_card_sequencer sc_card_sequencer_chk #(.WARM_ANY(WARM_ANY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vcc_en     (vcc_en),
  .io_en      (io_en),
  .card_clk_en(card_clk_en),
  .card_rst_n (card_rst_n),
  .active     (active),
  .start_clr  (start_clr),
  .early_evt  (early_evt),
  .mute_evt   (mute_evt),
  .warm_go    (warm_go)
);

// File: tb/sc_card_sequencer_tb_top.sv
module sc_card_sequencer_tb_top;
  localparam int RSTC = 8;
  localparam int MUTE = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_cmd = 1'b0, warm_req = 1'b0, card_present = 1'b1;
  logic supply_fault = 1'b0, overload = 1'b0, card_io = 1'b1, clk_tick = 1'b0;

  logic vcc, ioen, cen, crst, act, sclr, early, mute;
  logic vcc_a, ioen_a, cen_a, crst_a, act_a, sclr_a, early_a, mute_a;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sc_card_sequencer #(.RST_CYCLES(RSTC), .MUTE_LIMIT(MUTE), .WARM_ANY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .warm_req(warm_req),
    .card_present(card_present), .supply_fault(supply_fault), .overload(overload),
    .card_io_in(card_io), .clk_tick(clk_tick),
    .vcc_en(vcc), .io_en(ioen), .card_clk_en(cen), .card_rst_n(crst), .active(act),
    .start_clr(sclr), .early_evt(early), .mute_evt(mute));

  sc_card_sequencer #(.RST_CYCLES(RSTC), .MUTE_LIMIT(MUTE), .WARM_ANY(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .warm_req(warm_req),
    .card_present(card_present), .supply_fault(supply_fault), .overload(overload),
    .card_io_in(card_io), .clk_tick(clk_tick),
    .vcc_en(vcc_a), .io_en(ioen_a), .card_clk_en(cen_a), .card_rst_n(crst_a), .active(act_a),
    .start_clr(sclr_a), .early_evt(early_a), .mute_evt(mute_a));

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) clk_tick = 1'b1;
    @(negedge clk) clk_tick = 1'b0;
  endtask

  task automatic do_tick_io(input logic v);
    @(negedge clk) begin card_io = v; clk_tick = 1'b1; end
    @(negedge clk) clk_tick = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 outputs idle", {vcc, ioen, cen, crst, act, sclr, early, mute}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {vcc, ioen, cen, crst, act}, 0);
  endtask

  task automatic activate();
    @(negedge clk) start_cmd = 1'b1;
    @(negedge clk);
    check("R2 supply first", {vcc, ioen, cen, crst}, 4'b1000);
    check("R11 active with supply", act, 1);
    do_tick();
    check("R2 io second", {vcc, ioen, cen, crst}, 4'b1100);
    do_tick();
    check("R2 clock third", {vcc, ioen, cen, crst}, 4'b1110);
    for (int i = 0; i < RSTC - 1; i++) do_tick();
    check("R2 reset held", crst, 0);
    do_tick();
    check("R2 reset released", {crst, crst_a}, 2'b11);
  endtask

  task automatic answer_at(input int k, input bit exp_early, input string tag);
    for (int i = 0; i < k - 1; i++) do_tick_io(1'b1);
    do_tick_io(1'b0);
    check({tag, " early flag"}, early, 32'(exp_early));
    check("R3 reset stays released", crst, 1);
    @(negedge clk) card_io = 1'b1;
    check({tag, " pulse one cycle"}, early, 0);
  endtask

  task automatic deactivate();
    @(negedge clk) start_cmd = 1'b0;
    @(negedge clk);
    check("R8 reset drops first", {vcc, ioen, cen, crst}, 4'b1110);
    do_tick();
    check("R8 clock stops", {vcc, ioen, cen, crst}, 4'b1100);
    do_tick();
    check("R8 io off", {vcc, ioen, cen, crst}, 4'b1000);
    do_tick();
    check("R8 supply off", {vcc, act}, 0);
  endtask

  task automatic t_early_window();
    activate();
    answer_at(200, 1'b1, "R4 lower edge 200");
    deactivate();
    activate();
    answer_at(352, 1'b1, "R4 upper edge 352");
    deactivate();
    activate();
    answer_at(353, 1'b0, "R4 beyond 353");
    deactivate();
  endtask

  task automatic t_warm_after_answer();
    activate();
    answer_at(199, 1'b0, "R4 below 199");
    @(negedge clk) warm_req = 1'b1;
    @(negedge clk) warm_req = 1'b0;
    check("R6 warm ignored without mute", crst, 1);
    check("R7 alt mode accepts warm", crst_a, 0);
    do_tick();
    check("R6 still released", crst, 1);
    deactivate();
  endtask

  task automatic t_mute_warm();
    activate();
    for (int i = 0; i < MUTE - 1; i++) do_tick();
    check("R5 no mute before limit", mute, 0);
    do_tick();
    check("R5 mute at limit", mute, 1);
    check("R5 card stays up", {vcc, crst}, 2'b11);
    @(negedge clk) warm_req = 1'b1;
    @(negedge clk) warm_req = 1'b0;
    check("R6 warm after mute", crst, 0);
    check("R5 mute one cycle", mute, 0);
    for (int i = 0; i < RSTC - 1; i++) do_tick();
    check("R6 warm hold", crst, 0);
    do_tick();
    check("R6 warm release", crst, 1);
    answer_at(5, 1'b0, "R3 answer after warm");
    deactivate();
  endtask

  task automatic fault_case(input int which, input string tag);
    activate();
    @(negedge clk) begin
      if (which == 0) card_present = 1'b0;
      else if (which == 1) supply_fault = 1'b1;
      else overload = 1'b1;
    end
    @(negedge clk);
    check({tag, " clear request"}, sclr, 1);
    check({tag, " reset drops"}, {vcc, crst}, 2'b10);
    @(negedge clk);
    check({tag, " clear one cycle"}, sclr, 0);
    repeat (3) do_tick();
    check({tag, " supply off"}, vcc, 0);
    @(negedge clk) begin card_present = 1'b1; supply_fault = 1'b0; overload = 1'b0; end
    repeat (3) do_tick();
    check("R10 held start no restart", vcc, 0);
    @(negedge clk) start_cmd = 1'b0;
  endtask

  task automatic t_blocked_start();
    @(negedge clk) begin start_cmd = 1'b0; card_present = 1'b0; end
    @(negedge clk) start_cmd = 1'b1;
    repeat (2) do_tick();
    check("R10 absent card blocks start", vcc, 0);
    @(negedge clk) begin start_cmd = 1'b0; card_present = 1'b1; end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_early_window();
    t_warm_after_answer();
    t_mute_warm();
    fault_case(0, "R9 removal");
    fault_case(1, "R9 supply");
    fault_case(2, "R9 overload");
    t_blocked_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule